// File: doc/BRIEF.md
# Two-Level Fine-Grained Thread Scheduler

This block decides which thread start address runs next on a processing node that executes short, non-blocking threads grouped into activation frames. Each frame owns a small LIFO of pending thread addresses. Its bottom is an implicit exit marker, so an empty frame still holds exactly one thing to pop. A running thread ends with a stop command, which pops the most recent address of the current frame. A fork command pushes a new address onto that same frame. When the stop finds only the exit marker, the frame's own work is done and the scheduler swaps to the frame at the head of a runnable-frame FIFO.

Messages that arrive for a frame (inlets) push their thread address onto that frame's stack. This holds whether the frame is running, waiting or asleep. The first inlet that reaches a frame that is neither running nor waiting puts that frame at the tail of the runnable queue. A swapped-in frame therefore already holds its remotely posted work, and the address issued at the swap is its most recent pending entry. If no frame is runnable at a swap, the scheduler raises an idle flag. It wakes on its own as soon as an inlet makes a frame runnable. Every issued address appears one clock after the command together with its frame number.

Top module: `thread_sched`

## Requirements
- R1: While and after reset, idle_o is 1, run_valid_o is 0, ovf_err_o is 0, every frame stack holds only its exit marker and the runnable queue is empty.
- R2: A fork while a frame is running pushes cmd_fork_pc onto the current frame's stack and issues nothing. Fork and stop commands are ignored while idle_o is 1: nothing is issued and idle_o stays 1.
- R3: A stop (without fork) while the current frame holds entries pops the most recent one. In the next cycle run_valid_o is 1, run_pc_o is that address and run_frame_o is the current frame number. Popping is last-in, first-out.
- R4: A fork and a stop in the same cycle issue the forked address in the next cycle. The current frame's stack is left unchanged.
- R5: A stop that finds only the exit marker, with the queue non-empty, makes the queue head the current frame. In the next cycle its most recent pending address is issued with its frame number.
- R6: A frame is swapped out only when its stack is exhausted. A stop on a frame with entries issues from that frame even while other frames wait in the queue.
- R7: An inlet for a frame that is neither running nor queued pushes inlet_pc onto that frame's stack and appends the frame to the queue tail. Later inlets for a queued frame only push, and never append it again. Queued frames are served in arrival order.
- R8: An inlet for the running frame pushes onto its stack without queuing it. The next stop issues that address.
- R9: A swap that finds the queue empty sets idle_o to 1 with run_valid_o 0 in the next cycle. While idle, a frame that gets queued is dispatched on the clock edge after the one that queued it: run_valid_o is 1 and idle_o is 0 two edges after the inlet.
- R10: A push onto a stack already holding DEPTH entries above its exit marker is dropped. ovf_err_o is 1 for exactly the next cycle, and the stored entries are kept intact.
- R11: An inlet for the current frame in the same cycle as that frame's exit-marker stop is kept. The frame is queued again and later issues that inlet's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_fork | input | 1 | Fork command from the running thread |
| cmd_fork_pc | input | PCW | Start address of the forked thread |
| cmd_stop | input | 1 | Stop command: the running thread ends |
| inlet_valid | input | 1 | An inlet posts a thread to a frame |
| inlet_frame | input | $clog2(NF) | Target frame of the inlet |
| inlet_pc | input | PCW | Thread address posted by the inlet |
| run_valid_o | output | 1 | A next thread is issued this cycle |
| run_pc_o | output | PCW | Start address of the issued thread |
| run_frame_o | output | $clog2(NF) | Frame of the issued thread |
| idle_o | output | 1 | No frame is running |
| ovf_err_o | output | 1 | A push was dropped on a full stack |

## Verification
Two pairs of functions can fall in one cycle. The first pair is a fork and a stop from the same thread. The bench drives both in one cycle and expects the forked address to be issued at once. A later stop must then reach the older entries untouched. The second pair is a frame's exit-marker stop and an inlet aimed at that same frame. The bench provokes it with an empty queue and judges it by seeing idle_o rise for one cycle. The frame must then be redispatched with the inlet's address on the following edge, so the posted thread is not lost.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  // Where the next issued address comes from
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_STACK = 2'd1,
    SRC_FORK  = 2'd2,
    SRC_SWAP  = 2'd3
  } run_src_e;
endpackage

// File: rtl/tsched_frame_stack.sv
module tsched_frame_stack #(
  parameter int DEPTH = 4,
  parameter int PCW   = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pop_i,
  input  logic           push_a_i,
  input  logic [PCW-1:0] pc_a_i,
  input  logic           push_b_i,
  input  logic [PCW-1:0] pc_b_i,
  output logic [PCW-1:0] top_pc_o,
  output logic           empty_o,
  output logic           ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [PCW-1:0] mem_q [DEPTH];
  logic [CW:0]    base, slot_b, total;
  logic           acc_a, acc_b;
  logic [CW-1:0]  top_cnt;
  logic [IW-1:0]  top_idx;

  // Pop first, then the fork push, then the inlet push
  always_comb begin
    base    = {1'b0, cnt_q} - {{CW{1'b0}}, pop_i};
    acc_a   = push_a_i && (base < DEPTH_W);
    slot_b  = base + {{CW{1'b0}}, acc_a};
    acc_b   = push_b_i && (slot_b < DEPTH_W);
    total   = slot_b + {{CW{1'b0}}, acc_b};
    cnt_d   = total[CW-1:0];
    ovf_o   = (push_a_i && !acc_a) || (push_b_i && !acc_b);
    empty_o = (cnt_q == '0);
    top_cnt = cnt_q - CW'(1);
    top_idx = top_cnt[IW-1:0];
    top_pc_o = empty_o ? '0 : mem_q[top_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (acc_a && base == (CW+1)'(g))        mem_q[g] <= pc_a_i;
      else if (acc_b && slot_b == (CW+1)'(g)) mem_q[g] <= pc_b_i;
    end
  end

  // R10
  stk_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == DEPTH_W[CW-1:0]));
  // R5
  stk_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  // R3
  stk_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_a_i && !push_b_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/tsched_run_queue.sv
module tsched_run_queue #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_i,
  input  logic [$clog2(NF)-1:0] enq_id_i,
  input  logic          deq_i,
  output logic [$clog2(NF)-1:0] head_o,
  output logic          nonempty_o,
  output logic [NF-1:0] queued_o
);
  localparam int FW = $clog2(NF);
  localparam int CW = $clog2(NF + 1);
  localparam logic [FW-1:0] LAST = FW'(NF - 1);

  logic [FW-1:0] ids_q [NF];
  logic [FW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NF-1:0] queued_q, queued_d;

  always_comb begin
    wr_d     = wr_q;
    rd_d     = rd_q;
    cnt_d    = cnt_q;
    queued_d = queued_q;
    if (deq_i) begin
      rd_d = (rd_q == LAST) ? '0 : rd_q + FW'(1);
      queued_d[ids_q[rd_q]] = 1'b0;
    end
    if (enq_i) begin
      wr_d = (wr_q == LAST) ? '0 : wr_q + FW'(1);
      queued_d[enq_id_i] = 1'b1;
    end
    if (enq_i && !deq_i)      cnt_d = cnt_q + CW'(1);
    else if (deq_i && !enq_i) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= '0;
      rd_q     <= '0;
      cnt_q    <= '0;
      queued_q <= '0;
    end else begin
      wr_q     <= wr_d;
      rd_q     <= rd_d;
      cnt_q    <= cnt_d;
      queued_q <= queued_d;
    end
  end

  always_ff @(posedge clk) begin
    if (enq_i) ids_q[wr_q] <= enq_id_i;
  end

  assign head_o     = ids_q[rd_q];
  assign nonempty_o = (cnt_q != '0);
  assign queued_o   = queued_q;

  // R7
  q_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(queued_q) == int'(cnt_q));
  // R7
  q_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_i |-> ((int'(cnt_q) < NF) || deq_i));
  // R5
  q_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_i |-> nonempty_o);
endmodule

// File: rtl/thread_sched.sv
module thread_sched
  import tsched_pkg::*;
#(
  parameter int NF    = 4,
  parameter int DEPTH = 4,
  parameter int PCW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_fork,
  input  logic [PCW-1:0]        cmd_fork_pc,
  input  logic                  cmd_stop,
  input  logic                  inlet_valid,
  input  logic [$clog2(NF)-1:0] inlet_frame,
  input  logic [PCW-1:0]        inlet_pc,
  output logic                  run_valid_o,
  output logic [PCW-1:0]        run_pc_o,
  output logic [$clog2(NF)-1:0] run_frame_o,
  output logic                  idle_o,
  output logic                  ovf_err_o
);
  localparam int FW = $clog2(NF);

  logic           active_q, active_d;
  logic [FW-1:0]  cur_q, cur_d;
  logic           rv_q, rv_d;
  logic [PCW-1:0] rpc_q, rpc_d;
  logic [FW-1:0]  rfr_q, rfr_d;
  logic           ovf_q;

  logic [PCW-1:0] top_pc [NF];
  logic [NF-1:0]  empty, ovf, queued;
  logic [FW-1:0]  q_head;
  logic           q_ne;

  logic     bypass, local_pop, leaving, disp, enq;
  run_src_e src;

  always_comb begin
    bypass    = active_q && cmd_fork && cmd_stop;
    local_pop = active_q && cmd_stop && !cmd_fork && !empty[cur_q];
    leaving   = active_q && cmd_stop && !cmd_fork && empty[cur_q];
    disp      = (leaving || !active_q) && q_ne;
    enq       = inlet_valid && !queued[inlet_frame] &&
                !(active_q && (cur_q == inlet_frame) && !leaving);
  end

  for (genvar g = 0; g < NF; g++) begin : g_frame
    logic is_cur;
    assign is_cur = (cur_q == FW'(g));
    tsched_frame_stack #(.DEPTH(DEPTH), .PCW(PCW)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop_i    ((local_pop && is_cur) || (disp && (q_head == FW'(g)))),
      .push_a_i (active_q && cmd_fork && !cmd_stop && is_cur),
      .pc_a_i   (cmd_fork_pc),
      .push_b_i (inlet_valid && (inlet_frame == FW'(g))),
      .pc_b_i   (inlet_pc),
      .top_pc_o (top_pc[g]),
      .empty_o  (empty[g]),
      .ovf_o    (ovf[g])
    );
  end

  tsched_run_queue #(.NF(NF)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_i      (enq),
    .enq_id_i   (inlet_frame),
    .deq_i      (disp),
    .head_o     (q_head),
    .nonempty_o (q_ne),
    .queued_o   (queued)
  );

  // Next-state logic
  always_comb begin
    if (bypass)         src = SRC_FORK;
    else if (local_pop) src = SRC_STACK;
    else if (disp)      src = SRC_SWAP;
    else                src = SRC_NONE;

    rv_d  = (src != SRC_NONE);
    rfr_d = disp ? q_head : cur_q;
    case (src)
      SRC_FORK:  rpc_d = cmd_fork_pc;
      SRC_STACK: rpc_d = top_pc[cur_q];
      SRC_SWAP:  rpc_d = top_pc[q_head];
      default:   rpc_d = rpc_q;
    endcase

    active_d = active_q;
    cur_d    = cur_q;
    if (disp) begin
      active_d = 1'b1;
      cur_d    = q_head;
    end else if (leaving) begin
      active_d = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cur_q    <= '0;
      rv_q     <= 1'b0;
      rpc_q    <= '0;
      rfr_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      rv_q     <= rv_d;
      ovf_q    <= |ovf;
      if (disp) cur_q <= cur_d;
      if (rv_d) begin
        rpc_q <= rpc_d;
        rfr_q <= rfr_d;
      end
    end
  end

  assign run_valid_o = rv_q;
  assign run_pc_o    = rpc_q;
  assign run_frame_o = rfr_q;
  assign idle_o      = !active_q;
  assign ovf_err_o   = ovf_q;

  // R4
  fork_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cmd_fork && cmd_stop) |=>
      (run_valid_o && run_pc_o == $past(cmd_fork_pc)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && !q_ne) |=> idle_o);
  // R3
  run_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid_o |-> !idle_o);
  // R6
  no_early_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cmd_stop && !empty[cur_q]) |=> (run_frame_o == $past(cur_q)));
endmodule

// File: tb/tb_thread_sched.sv
`timescale 1ns/1ps
module tb_thread_sched;
  localparam int NF = 4;
  localparam int DEPTH = 4;
  localparam int PCW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_fork, cmd_stop, inlet_valid;
  logic [PCW-1:0] cmd_fork_pc, inlet_pc;
  logic [1:0] inlet_frame;
  logic run_valid_o, idle_o, ovf_err_o;
  logic [PCW-1:0] run_pc_o;
  logic [1:0] run_frame_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thread_sched #(.NF(NF), .DEPTH(DEPTH), .PCW(PCW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_fork(cmd_fork), .cmd_fork_pc(cmd_fork_pc), .cmd_stop(cmd_stop),
    .inlet_valid(inlet_valid), .inlet_frame(inlet_frame), .inlet_pc(inlet_pc),
    .run_valid_o(run_valid_o), .run_pc_o(run_pc_o), .run_frame_o(run_frame_o),
    .idle_o(idle_o), .ovf_err_o(ovf_err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of commands, then sample just after the edge
  task automatic cyc(input logic f, input logic [PCW-1:0] fpc, input logic s,
                     input logic i, input logic [1:0] ifr, input logic [PCW-1:0] ipc);
    @(negedge clk);
    cmd_fork = f; cmd_fork_pc = fpc; cmd_stop = s;
    inlet_valid = i; inlet_frame = ifr; inlet_pc = ipc;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_run(input string req, input int pc, input int fr);
    chk(req, "run_valid", int'(run_valid_o), 1);
    chk(req, "run_pc", int'(run_pc_o), pc);
    chk(req, "run_frame", int'(run_frame_o), fr);
  endtask

  task automatic expect_none(input string req);
    chk(req, "run_valid", int'(run_valid_o), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cmd_fork = 0; cmd_fork_pc = '0; cmd_stop = 0;
    inlet_valid = 0; inlet_frame = '0; inlet_pc = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "idle in reset", int'(idle_o), 1);
    chk("R1", "run_valid in reset", int'(run_valid_o), 0);
    chk("R1", "ovf in reset", int'(ovf_err_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0);
    chk("R1", "idle after reset", int'(idle_o), 1);
    expect_none("R1");
  endtask

  task automatic t_idle_ignore;
    cyc(0, 0, 1, 0, 0, 0);
    expect_none("R2");
    chk("R2", "idle after stop", int'(idle_o), 1);
    cyc(1, 16'h0999, 1, 0, 0, 0);
    expect_none("R2");
    chk("R2", "idle after fork+stop", int'(idle_o), 1);
  endtask

  task automatic t_wake_and_lifo;
    cyc(0, 0, 0, 1, 2'd1, 16'h0100);
    expect_none("R9");
    chk("R9", "idle one edge after inlet", int'(idle_o), 1);
    cyc(0, 0, 0, 0, 0, 0);
    expect_run("R9", 16'h0100, 1);
    chk("R9", "idle cleared", int'(idle_o), 0);
    cyc(1, 16'h0200, 0, 0, 0, 0);
    expect_none("R2");
    cyc(1, 16'h0201, 0, 0, 0, 0);
    expect_none("R2");
    cyc(0, 0, 1, 0, 0, 0);
    expect_run("R3", 16'h0201, 1);
    cyc(0, 0, 1, 0, 0, 0);
    expect_run("R3", 16'h0200, 1);
  endtask

  task automatic t_queue_and_swap;
    cyc(0, 0, 0, 1, 2'd2, 16'h00A0);
    cyc(0, 0, 0, 1, 2'd3, 16'h00B0);
    cyc(0, 0, 0, 1, 2'd2, 16'h00A1);
    expect_none("R7");
    cyc(1, 16'h0300, 1, 0, 0, 0);
    expect_run("R4", 16'h0300, 1);
    cyc(0, 0, 1, 0, 0, 0);
    expect_run("R5", 16'h00A1, 2);
    cyc(0, 0, 1, 0, 0, 0);
    expect_run("R6", 16'h00A0, 2);
    cyc(0, 0, 1, 0, 0, 0);
    expect_run("R7", 16'h00B0, 3);
  endtask

  task automatic t_inlet_running;
    cyc(0, 0, 0, 1, 2'd3, 16'h00C0);
    expect_none("R8");
    cyc(0, 0, 1, 0, 0, 0);
    expect_run("R8", 16'h00C0, 3);
    cyc(0, 0, 1, 0, 0, 0);
    expect_none("R9");
    chk("R9", "idle on empty queue", int'(idle_o), 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9", "idle stays", int'(idle_o), 1);
  endtask

  task automatic t_overflow;
    cyc(0, 0, 0, 1, 2'd0, 16'h0010);
    cyc(0, 0, 0, 0, 0, 0);
    expect_run("R10", 16'h0010, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      cyc(1, PCW'(16'h0010 + k), 0, 0, 0, 0);
      chk("R10", "no ovf while filling", int'(ovf_err_o), 0);
    end
    cyc(1, 16'h0015, 0, 0, 0, 0);
    chk("R10", "ovf pulse", int'(ovf_err_o), 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R10", "ovf one cycle", int'(ovf_err_o), 0);
    expect_run("R10", 16'h0014, 0);
    for (int k = 3; k >= 1; k--) begin
      cyc(0, 0, 1, 0, 0, 0);
      expect_run("R10", 16'h0010 + k, 0);
    end
    cyc(0, 0, 1, 0, 0, 0);
    chk("R10", "idle after drain", int'(idle_o), 1);
  endtask

  task automatic t_exit_and_inlet;
    cyc(0, 0, 0, 1, 2'd1, 16'h0070);
    cyc(0, 0, 0, 0, 0, 0);
    expect_run("R11", 16'h0070, 1);
    cyc(0, 0, 1, 1, 2'd1, 16'h0071);
    expect_none("R11");
    chk("R11", "idle for one cycle", int'(idle_o), 1);
    cyc(0, 0, 0, 0, 0, 0);
    expect_run("R11", 16'h0071, 1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    t_wake_and_lifo();
    t_queue_and_swap();
    t_inlet_running();
    t_overflow();
    t_exit_and_inlet();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule